// File: doc/BRIEF.md
# Page-Buffered Self-Timed Byte Store

This block models a byte-wide nonvolatile store behind an SRAM-style bus. The bus has an active-low chip enable, an active-low output enable and an active-low write enable. The main array holds 8192 bytes. A separate 64-byte identification area is reached by raising `id_sel`. All bus inputs are sampled on `clk`. A write strobe is counted on the clock where chip enable and write enable first become active together, and a read on the clock where chip enable and output enable first become active with write enable inactive.

Writes do not go straight to the array. Each accepted write drops its byte into a 64-entry page buffer and arms a load window. The page is held by its upper address bits plus `id_sel`. The page closes in one of two ways: no further strobe arrives within the window, or a strobe for a different page arrives. After it closes, a self-timed commit of `WRITE_CYC` clocks copies every loaded byte into the array. No bus activity is needed for this.

During the commit the block ignores write strobes, and reads return status instead of stored data:
- Bit 7 is the complement of bit 7 of the last byte loaded.
- Bit 6 flips on every read.
- Bits 5:0 repeat the low bits of that last byte.

Software detects the end of the write by polling until bit 7 matches the data it wrote.

Top module: `paged_nv_store`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 for every other combination, including right after reset.
- R2: A single byte written to an idle block reads back unchanged once the commit has ended.
- R3: Up to 64 bytes sharing `addr[12:6]` and `id_sel`, written in any order, are all committed by one page commit.
- R4: A strobe for the open page that arrives fewer than `LOAD_WIN` clocks after the previous one is added to the same page.
- R5: A strobe whose `{id_sel, addr[12:6]}` differs from the open page closes the page at once, and that byte is discarded.
- R6: During the commit, a read returns bit 7 equal to the complement of bit 7 of the last loaded byte, and bits 5:0 equal to its bits 5:0.
- R7: During the commit, bit 6 of the read data takes opposite values on any two successive reads.
- R8: Write strobes that arrive during the commit change neither the array nor the status.
- R9: The commit lasts `WRITE_CYC` clocks after the page closes, and reads return true array data afterwards.
- R10: With `id_sel`=1, `addr[5:0]` selects one of 64 identification bytes that are separate from the main array.
- R11: Read data appears on `dout` one clock after the read starts and then tracks `addr` while the read stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_sel | input | 1 | Selects the 64-byte identification area |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status |
| dq_oe | output | 1 | Drive enable for the external data pins (0 = tri-stated) |

## Verification
The assertions assume that the bus inputs change only away from the sampling edge and that each strobe is held for at least one clock. They also assume that `WRITE_CYC` is at least the page size, so the commit scan reaches every buffer entry. The stimulus meets these assumptions as follows:
- It drives every input on the falling clock edge.
- It holds each strobe for exactly one clock, then releases it for one clock.
- It never overlaps write enable with a read.

This keeps every strobe a clean single event for both the bench's polling model and the checker's status properties.

// File: rtl/paged_nv_store.sv
module paged_nv_store #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_W    = 6,
  parameter int LOAD_WIN  = 16,
  parameter int WRITE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dq_oe
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TAG_W = ADDR_W - PAGE_W;
  localparam int TMR_W = $clog2(LOAD_WIN);
  localparam int CNT_W = $clog2(WRITE_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LOAD_WIN - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE);

  typedef enum logic [1:0] {IDLE, LOAD, COMMIT} st_t;

  st_t               state;
  logic [7:0]        mem    [1 << ADDR_W];
  logic [7:0]        id_mem [PAGE];
  logic [7:0]        pbuf   [PAGE];
  logic [PAGE-1:0]   pvalid;
  logic [TAG_W:0]    tag_q;
  logic [TMR_W-1:0]  timer;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        last_q;
  logic              tog_q, wr_q, rd_q;
  logic [7:0]        dout_q;

  wire              wr_now  = !ce_n && !we_n;
  wire              rd_now  = !ce_n && !oe_n && we_n;
  wire              wr_evt  = wr_now && !wr_q;
  wire              rd_evt  = rd_now && !rd_q;
  wire [TAG_W:0]    tag_in  = {id_sel, addr[ADDR_W-1:PAGE_W]};
  wire [PAGE_W-1:0] slot    = addr[PAGE_W-1:0];
  wire              busy    = (state == COMMIT);
  wire              same_pg = (tag_in == tag_q);
  wire              accept  = wr_evt && ((state == IDLE) || (state == LOAD && same_pg));
  wire [PAGE_W-1:0] cslot   = cnt[PAGE_W-1:0];
  wire              cwrite  = busy && (cnt < CNT_PAGE) && pvalid[cslot];

  assign dout  = dout_q;
  assign dq_oe = rd_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_now;
      rd_q <= rd_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      tag_q  <= '0;
      timer  <= '0;
      cnt    <= '0;
      pvalid <= '0;
      last_q <= '0;
    end else begin
      if (accept) begin
        last_q <= din;
        timer  <= '0;
      end
      case (state)
        IDLE: if (wr_evt) begin
          state        <= LOAD;
          tag_q        <= tag_in;
          pvalid       <= '0;
          pvalid[slot] <= 1'b1;
        end
        LOAD: begin
          if (accept) begin
            pvalid[slot] <= 1'b1;
          end else if (wr_evt || timer == TMR_LAST) begin
            state <= COMMIT;
            cnt   <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        COMMIT: begin
          if (cnt == CNT_LAST) begin
            state  <= IDLE;
            pvalid <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (busy && rd_evt) tog_q <= !tog_q;
  end

  always_ff @(posedge clk) begin
    if (accept) pbuf[slot] <= din;
    if (cwrite) begin
      if (tag_q[TAG_W]) id_mem[cslot] <= pbuf[cslot];
      else mem[{tag_q[TAG_W-1:0], cslot}] <= pbuf[cslot];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else if (busy) dout_q <= {!last_q[7], rd_evt ? !tog_q : tog_q, last_q[5:0]};
    else if (id_sel) dout_q <= id_mem[slot];
    else dout_q <= mem[addr];
  end
endmodule

// File: rtl/paged_nv_store_chk.sv
module paged_nv_store_chk #(
  parameter int WRITE_CYC = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic [7:0] dout,
  input logic       busy,
  input logic       tog,
  input logic [7:0] last
);
  logic rd_prev;
  int   busy_run;
  wire  rd_act   = !ce_n && !oe_n && we_n;
  wire  rd_start = rd_act && !rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      busy_run <= 0;
    end else begin
      rd_prev  <= rd_act;
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !dq_oe); // R1
  AST_POLL_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (dout[7] == !last[7])); // R6
  AST_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (dout[5:0] == last[5:0])); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_start) |=> (tog != $past(tog))); // R7
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rd_start) |=> $stable(tog)); // R7
  AST_BUSY_LAST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(last)); // R8
  AST_COMMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= WRITE_CYC); // R9
endmodule

bind paged_nv_store paged_nv_store_chk #(.WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dq_oe(dq_oe), .dout(dout), .busy(busy), .tog(tog_q), .last(last_q)
);

// File: tb/paged_nv_store_test.sv
module paged_nv_store_test;
  localparam int LOAD_WIN  = 16;
  localparam int WRITE_CYC = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, id_sel = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dq_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] ref_main [int];
  logic [7:0] ref_id   [int];

  paged_nv_store #(.LOAD_WIN(LOAD_WIN), .WRITE_CYC(WRITE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .id_sel(id_sel), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  // {close, id, addr[12:0], data[7:0]}
  localparam logic [22:0] VEC [13] = '{
    {1'b0, 1'b0, 13'h0105, 8'h3C},
    {1'b0, 1'b0, 13'h0100, 8'hA5},
    {1'b1, 1'b0, 13'h013F, 8'h81},
    {1'b0, 1'b0, 13'h1FC0, 8'h5A},
    {1'b1, 1'b0, 13'h1FFF, 8'hF0},
    {1'b0, 1'b1, 13'h0005, 8'h77},
    {1'b1, 1'b1, 13'h0000, 8'h11},
    {1'b1, 1'b0, 13'h0005, 8'h99},
    {1'b0, 1'b0, 13'h0810, 8'h00},
    {1'b0, 1'b0, 13'h0811, 8'hFF},
    {1'b1, 1'b0, 13'h0812, 8'h42},
    {1'b1, 1'b0, 13'h0240, 8'hC3},
    {1'b1, 1'b0, 13'h0300, 8'hAA}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit id, input logic [12:0] a, input logic [7:0] d);
    id_sel = id; addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input bit id, input logic [12:0] a, output logic [7:0] d, output logic oe);
    id_sel = id; addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    d = dout; oe = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic note(input bit id, input logic [12:0] a, input logic [7:0] d);
    if (id) ref_id[int'(a[5:0])] = d;
    else ref_main[int'(a)] = d;
  endtask

  task automatic wait_done(input bit id, input logic [12:0] a, input logic [7:0] last);
    logic [7:0] d, d2;
    logic oe;
    bit done;
    repeat (LOAD_WIN + 2) @(negedge clk);
    rd(id, a, d, oe);
    chk(d[7] == ~last[7], "R6 poll bit7", d[7], ~last[7]);
    chk(d[5:0] == last[5:0], "R6 status low bits", d[5:0], last[5:0]);
    rd(id, a, d2, oe);
    chk(d2[6] != d[6], "R7 toggle bit", d2[6], ~d[6]);
    done = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      rd(id, a, d, oe);
      if (d[7] == last[7]) done = 1'b1;
    end
    chk(done, "R9 write completes", done, 1);
    chk(d == last, "R9 true data after commit", d, last);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 output enable decoding after reset
    chk(dq_oe == 1'b0, "R1 reset idle", dq_oe, 0);
    ce_n = 0; oe_n = 0; we_n = 0; #1;
    chk(dq_oe == 1'b0, "R1 we low", dq_oe, 0);
    ce_n = 0; oe_n = 1; we_n = 1; #1;
    chk(dq_oe == 1'b0, "R1 oe high", dq_oe, 0);
    ce_n = 1; oe_n = 0; we_n = 1; #1;
    chk(dq_oe == 1'b0, "R1 ce high", dq_oe, 0);
    ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk(dq_oe == 1'b1, "R1 read enabled", dq_oe, 1);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    // vector table: partial pages, id area, single bytes
    foreach (VEC[i]) begin
      wr(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);
      note(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);
      if (VEC[i][22]) wait_done(VEC[i][21], VEC[i][20:8], VEC[i][7:0]);
    end
    foreach (VEC[i]) begin
      logic [7:0] e;
      e = VEC[i][21] ? ref_id[int'(VEC[i][13:8])] : ref_main[int'(VEC[i][20:8])];
      rd(VEC[i][21], VEC[i][20:8], d, oe);
      chk(d == e, "R2 R3 R10 readback", d, e);
    end
    rd(1'b0, 13'h0005, d, oe);
    chk(d == 8'h99, "R10 main distinct from id", d, 8'h99);
    rd(1'b1, 13'h0005, d, oe);
    chk(d == 8'h77, "R10 id byte", d, 8'h77);

    // R11 data follows address while read held
    id_sel = 0; addr = 13'h0100; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk(dout == 8'hA5, "R11 read latency", dout, 8'hA5);
    addr = 13'h0105;
    @(negedge clk);
    chk(dout == 8'h3C, "R11 address follow", dout, 8'h3C);
    ce_n = 1; oe_n = 1;
    @(negedge clk);

    // R3 full page, reverse order
    for (int i = 63; i >= 0; i--) begin
      wr(1'b0, 13'h1000 + 13'(i), 8'(i * 3 + 1));
      note(1'b0, 13'h1000 + 13'(i), 8'(i * 3 + 1));
    end
    wait_done(1'b0, 13'h1000, 8'h01);
    for (int i = 0; i < 64; i++) begin
      rd(1'b0, 13'h1000 + 13'(i), d, oe);
      chk(d == 8'(i * 3 + 1), "R3 full page byte", d, 8'(i * 3 + 1));
    end

    // R4 strobe inside the load window joins the page
    wr(1'b0, 13'h0400, 8'h21);
    repeat (LOAD_WIN - 4) @(negedge clk);
    wr(1'b0, 13'h0401, 8'hB2);
    wait_done(1'b0, 13'h0401, 8'hB2);
    rd(1'b0, 13'h0400, d, oe);
    chk(d == 8'h21, "R4 first byte", d, 8'h21);
    rd(1'b0, 13'h0401, d, oe);
    chk(d == 8'hB2, "R4 late byte same page", d, 8'hB2);

    // R5 page mismatch closes the page and drops the byte
    wr(1'b0, 13'h0200, 8'h12);
    wr(1'b0, 13'h0240, 8'h34);
    wait_done(1'b0, 13'h0200, 8'h12);
    rd(1'b0, 13'h0240, d, oe);
    chk(d == 8'hC3, "R5 mismatch byte dropped", d, 8'hC3);
    rd(1'b0, 13'h0200, d, oe);
    chk(d == 8'h12, "R5 open page committed", d, 8'h12);

    // R8 writes while busy are ignored
    wr(1'b0, 13'h0310, 8'h01);
    repeat (LOAD_WIN + 4) @(negedge clk);
    wr(1'b0, 13'h0300, 8'h55);
    wr(1'b0, 13'h0301, 8'h66);
    wait_done(1'b0, 13'h0310, 8'h01);
    rd(1'b0, 13'h0300, d, oe);
    chk(d == 8'hAA, "R8 busy write ignored", d, 8'hAA);
    rd(1'b0, 13'h0310, d, oe);
    chk(d == 8'h01, "R8 committed byte", d, 8'h01);

    // R9 commit duration window
    wr(1'b0, 13'h0600, 8'h0F);
    repeat (LOAD_WIN + WRITE_CYC - 12) @(negedge clk);
    rd(1'b0, 13'h0600, d, oe);
    chk(d[7] == 1'b1, "R9 still busy near end", d, 8'h8F);
    repeat (20) @(negedge clk);
    rd(1'b0, 13'h0600, d, oe);
    chk(d == 8'h0F, "R9 done after window", d, 8'h0F);
    chk(oe == 1'b1, "R1 drive during read", oe, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule